// File: doc/BRIEF.md
# Watchdog Timer With Unlock-Sequence Disable

This block is a 32-bit down counter behind a small register bus. It can serve two purposes. By default it is an interval timer. When it reaches zero it raises an event flag and, if allowed, an interrupt. Software can switch it into watchdog mode. In that mode, reaching zero instead sends a single-cycle reset request to the chip's reset controller and records that a reset was sent.

Once the watchdog mode is on, an ordinary control write cannot turn it off. The only way out is a two-step unlock. Software writes a first key and then a second key to the disable register, with no other bus write between them.

A prescaler divides the clock by the programmed value plus one before each count step. The load register can optionally refill the counter when it reaches zero.

Top module: `wdt_core`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, and `irq` and `rst_req` are low.
- R2: A write to the load offset (0x20) sets both the reload value and the live count (0x24). Writes to the count offset have no effect.
- R3: With enable (control bit 0) set and prescale value P in control bits 15:8, the count drops by one every P+1 clock cycles.
- R4: In timer mode, a count step from 1 to 0 sets status bit 0 (offset 0x2C). `irq` is high while that bit and interrupt-enable (control bit 2) are both set.
- R5: Writing 1 to status bit 0 clears it. Writing 0 to it leaves it unchanged.
- R6: At zero with auto-reload (control bit 1) set, the next count step refills the count from the load value. Without auto-reload, the count stays at 0.
- R7: Control bit 3 (watchdog mode) is set by writing 1 to it. Writing 0 to it is ignored.
- R8: In watchdog mode, a count step from 1 to 0 drives `rst_req` high for exactly one cycle and sets reset-sent bit 0 (offset 0x30). It does not set the status bit.
- R9: The reset-sent bit is cleared only by writing 1 to it, or by reset. It survives the block's own reset request and all other writes.
- R10: Writing 0x12345678 and then 0x87654321 to the disable offset (0x34) clears the watchdog mode and returns the block to timer behaviour. The second key written alone does nothing.
- R11: Any other write between the two keys, to any offset, cancels the pending first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Timer interrupt |
| rst_req | output | 1 | One-cycle watchdog reset request |

## Verification
The embedded properties assume that `wr_en` is never unknown and that at most one write arrives per cycle. The bench never pulses `wr_en` twice in the same cycle, so each write is a single, distinct bus event.

They also assume that the count only changes on a prescaler tick or a load write. This is why each scenario either disables counting before reprogramming or reads the count only at known tick points.

Stimulus changes only at falling clock edges. Each write strobe lasts exactly one cycle, followed by at least one idle cycle. The unlock checks therefore test "no other write between the keys", not timing gaps between keys.

// File: rtl/wdt_pkg.sv
// Package: shared offsets, control-field positions and unlock keys for the
// watchdog timer. Assumes byte-addressed, word-aligned 32-bit registers.
package wdt_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int PRESC_W = 8;

    localparam logic [ADDR_W-1:0] OFS_LOAD  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_RSENT = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_DIS   = 8'h34;

    localparam int BIT_RUN    = 0;
    localparam int BIT_AUTO   = 1;
    localparam int BIT_IEN    = 2;
    localparam int BIT_WDMODE = 3;
    localparam int PRESC_LSB  = 8;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 32'h1234_5678;
    localparam logic [DATA_W-1:0] KEY_SECOND = 32'h8765_4321;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               wd_mode;
        logic               irq_en;
        logic               auto_rl;
        logic               run;
    } ctrl_t;
endpackage

// File: rtl/wdt_prescaler.sv
// Prescaler: emits a one-cycle tick every DIV+1 cycles while RUN is high.
// Assumes DIV may change at any time; the phase restarts whenever RUN drops.
module wdt_prescaler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] phase;

    assign tick = run && (phase == div);

    // Advance the phase counter, wrapping at the divide value.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    phase <= '0;
        else if (phase == div) phase <= '0;
        else                   phase <= phase + 1'b1;
    end

    assert_phase_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run && $past(run) && $past(tick) |-> phase == '0);
endmodule

// File: rtl/wdt_downcounter.sv
// Down counter: steps once per tick, flags the 1->0 step, optionally refills
// from the reload value when a tick finds it at zero. A load write wins over a tick.
module wdt_downcounter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_wr,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] reload_val,
    input  logic         auto_rl,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         hit
);
    localparam logic [W-1:0] ONE = W'(1);

    assign hit = tick && !load_wr && (count == ONE);

    // Update the live count from load writes, refills and ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)              count <= '0;
        else if (load_wr)        count <= load_val;
        else if (tick) begin
            if (count != '0)     count <= count - 1'b1;
            else if (auto_rl)    count <= reload_val;
        end
    end

    assert_count_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) && !$past(load_wr) |-> $stable(count));
    assert_hit_lands_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> count == '0);
endmodule

// File: rtl/wdt_unlock.sv
// Unlock detector: arms on the first key at the disable offset, fires on the
// second key when armed. Any other write disarms. Assumes one write per cycle.
module wdt_unlock
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              to_dis,
    input  logic [DATA_W-1:0] wdata,
    output logic              unlock
);
    logic armed;

    assign unlock = wr_en && to_dis && armed && (wdata == KEY_SECOND);

    // Track whether the last write was the first key.
    always_ff @(posedge clk) begin
        if (!rst_n)     armed <= 1'b0;
        else if (wr_en) armed <= to_dis && (wdata == KEY_FIRST);
    end

    assert_arm_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> $past(wr_en && to_dis && wdata == KEY_FIRST));
    assert_unlock_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        unlock |=> !armed);
endmodule

// File: rtl/wdt_core.sv
// Watchdog timer top: register decode, control and mode latch, event/status,
// reset-sent flag and reset request. Assumes word-aligned offsets and one
// write per cycle; reads are combinational on addr.
module wdt_core
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq,
    output logic              rst_req
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count;
    logic              stat_q;
    logic              rsent_q;
    logic              tick;
    logic              hit;
    logic              unlock;

    logic wr_load, wr_ctrl, wr_stat, wr_rsent, wr_dis;
    assign wr_load  = wr_en && (addr == OFS_LOAD);
    assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
    assign wr_stat  = wr_en && (addr == OFS_STAT);
    assign wr_rsent = wr_en && (addr == OFS_RSENT);
    assign wr_dis   = wr_en && (addr == OFS_DIS);

    wdt_prescaler #(.W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .div(ctrl.presc), .tick(tick)
    );

    wdt_downcounter #(.W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load_wr(wr_load), .load_val(wdata),
        .reload_val(reload_q), .auto_rl(ctrl.auto_rl), .tick(tick),
        .count(count), .hit(hit)
    );

    wdt_unlock u_unlock (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .to_dis(addr == OFS_DIS),
        .wdata(wdata), .unlock(unlock)
    );

    // Hold the reload value written at the load offset.
    always_ff @(posedge clk) begin
        if (!rst_n)       reload_q <= '0;
        else if (wr_load) reload_q <= wdata;
    end

    // Control fields; the watchdog bit only sets from writes and clears on unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl.run     <= wdata[BIT_RUN];
                ctrl.auto_rl <= wdata[BIT_AUTO];
                ctrl.irq_en  <= wdata[BIT_IEN];
                ctrl.presc   <= wdata[PRESC_LSB +: PRESC_W];
                if (wdata[BIT_WDMODE]) ctrl.wd_mode <= 1'b1;
            end
            if (unlock) ctrl.wd_mode <= 1'b0;
        end
    end

    // Timer-mode zero event flag, write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                        stat_q <= 1'b0;
        else if (hit && !ctrl.wd_mode)     stat_q <= 1'b1;
        else if (wr_stat && wdata[0])      stat_q <= 1'b0;
    end

    // Reset-sent flag and one-cycle reset request in watchdog mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsent_q <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            rst_req <= hit && ctrl.wd_mode;
            if (hit && ctrl.wd_mode)          rsent_q <= 1'b1;
            else if (wr_rsent && wdata[0])    rsent_q <= 1'b0;
        end
    end

    assign irq = stat_q && ctrl.irq_en;

    // Read multiplexer over the register offsets.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_LOAD:  rdata = reload_q;
            OFS_COUNT: rdata = count;
            OFS_CTRL:  begin
                rdata[BIT_RUN]    = ctrl.run;
                rdata[BIT_AUTO]   = ctrl.auto_rl;
                rdata[BIT_IEN]    = ctrl.irq_en;
                rdata[BIT_WDMODE] = ctrl.wd_mode;
                rdata[PRESC_LSB +: PRESC_W] = ctrl.presc;
            end
            OFS_STAT:  rdata[0] = stat_q;
            OFS_RSENT: rdata[0] = rsent_q;
            default:   rdata = '0;
        endcase
    end

    assert_wd_exit_only_unlock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.wd_mode) |-> $past(unlock));
    assert_rstreq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);
    assert_rstreq_records_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> rsent_q);
    assert_rsent_clear_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsent_q) |-> $past(wr_en && addr == OFS_RSENT && wdata[0]));
    assert_stat_timer_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q) |-> !$past(ctrl.wd_mode));
endmodule

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;
    localparam logic [7:0] A_LOAD = 8'h20, A_CNT = 8'h24, A_CTRL = 8'h28,
                           A_STAT = 8'h2C, A_RS = 8'h30, A_DIS = 8'h34;
    localparam logic [31:0] K1 = 32'h1234_5678, K2 = 32'h8765_4321;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq, rst_req;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;

    wdt_core uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 8'h00; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
        addr = 8'h00;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(A_CNT, v);  check("R1 count", v, 0);
        rd(A_CTRL, v); check("R1 ctrl", v, 0);
        rd(A_STAT, v); check("R1 status", v, 0);
        rd(A_RS, v);   check("R1 rsent", v, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 rst_req", {31'b0, rst_req}, 0);
    endtask

    task automatic t_load();
        logic [31:0] v;
        wr(A_LOAD, 32'h0000_1234);
        rd(A_CNT, v);  check("R2 count after load", v, 32'h1234);
        rd(A_LOAD, v); check("R2 load readback", v, 32'h1234);
        wr(A_CNT, 32'h55);
        rd(A_CNT, v);  check("R2 count write ignored", v, 32'h1234);
    endtask

    task automatic t_prescale();
        logic [31:0] v;
        wr(A_LOAD, 10);
        wr(A_CTRL, (32'd2 << 8) | 32'h1);
        repeat (2) @(negedge clk);
        rd(A_CNT, v); check("R3 no step before P+1", v, 10);
        @(negedge clk);
        rd(A_CNT, v); check("R3 first step", v, 9);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R3 second step", v, 8);
        wr(A_CTRL, 0);
    endtask

    task automatic t_timer_irq();
        logic [31:0] v;
        wr(A_LOAD, 3);
        wr(A_CTRL, 32'h5);
        repeat (2) @(negedge clk);
        rd(A_STAT, v); check("R4 status before zero", v, 0);
        @(negedge clk);
        rd(A_STAT, v); check("R4 status at zero", v, 1);
        check("R4 irq", {31'b0, irq}, 1);
        wr(A_STAT, 0);
        rd(A_STAT, v); check("R5 write 0 keeps status", v, 1);
        wr(A_STAT, 1);
        rd(A_STAT, v); check("R5 write 1 clears", v, 0);
        check("R5 irq low", {31'b0, irq}, 0);
        repeat (3) @(negedge clk);
        rd(A_CNT, v); check("R6 no reload stays 0", v, 0);
        rd(A_STAT, v); check("R6 no repeat event", v, 0);
        wr(A_CTRL, 0);
    endtask

    task automatic t_reload();
        logic [31:0] v;
        wr(A_LOAD, 2);
        wr(A_CTRL, 32'h3);
        repeat (2) @(negedge clk);
        rd(A_CNT, v); check("R6 reached zero", v, 0);
        @(negedge clk);
        rd(A_CNT, v); check("R6 refilled", v, 2);
        wr(A_CTRL, 0);
        wr(A_STAT, 1);
    endtask

    task automatic t_wd_bit();
        logic [31:0] v;
        wr(A_CTRL, 32'h8);
        rd(A_CTRL, v); check("R7 wd set", v, 32'h8);
        wr(A_CTRL, 0);
        rd(A_CTRL, v); check("R7 write 0 ignored", v, 32'h8);
    endtask

    task automatic t_wd_reset();
        logic [31:0] v;
        wr(A_LOAD, 2);
        wr(A_CTRL, 32'hD);
        @(negedge clk);
        check("R8 no request early", {31'b0, rst_req}, 0);
        @(negedge clk);
        check("R8 request", {31'b0, rst_req}, 1);
        rd(A_STAT, v); check("R8 status untouched", v, 0);
        rd(A_RS, v);   check("R8 rsent set", v, 1);
        check("R8 no irq", {31'b0, irq}, 0);
        @(negedge clk);
        check("R8 single cycle", {31'b0, rst_req}, 0);
        rd(A_RS, v); check("R9 rsent holds", v, 1);
        wr(A_CTRL, 32'h8);
        wr(A_RS, 0);
        rd(A_RS, v); check("R9 write 0 keeps", v, 1);
        wr(A_LOAD, 5);
        rd(A_RS, v); check("R9 other write keeps", v, 1);
        wr(A_RS, 1);
        rd(A_RS, v); check("R9 write 1 clears", v, 0);
    endtask

    task automatic t_unlock_cancel();
        logic [31:0] v;
        wr(A_DIS, K1);
        wr(A_LOAD, 7);
        wr(A_DIS, K2);
        rd(A_CTRL, v); check("R11 interleaved write cancels", v[3], 1);
        wr(A_DIS, K2);
        rd(A_CTRL, v); check("R10 second key alone", v[3], 1);
    endtask

    task automatic t_unlock();
        logic [31:0] v;
        wr(A_DIS, K1);
        wr(A_DIS, K2);
        rd(A_CTRL, v); check("R10 unlock clears wd", v[3], 0);
        wr(A_LOAD, 1);
        wr(A_CTRL, 32'h1);
        @(negedge clk);
        rd(A_STAT, v); check("R10 timer event after unlock", v, 1);
        check("R10 no reset request", {31'b0, rst_req}, 0);
        wr(A_CTRL, 0);
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_load();
        t_prescale();
        t_timer_irq();
        t_reload();
        t_wd_bit();
        t_wd_reset();
        t_unlock_cancel();
        t_unlock();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule